// File: doc/BRIEF.md
# Serial Output Freeze Controller

This block lets a host stop or restart individual clock outputs of a clock distribution tree without creating short pulses. A serial line (`sdata`) and its free-running clock (`sclk`) carry a frame: one low start bit, then twelve enable bits. Once all twelve bits have arrived, they replace the freeze-enable register in one step. Each enable bit then passes into the clock domain of the output it controls. There it opens or closes an AND gate on that clock, and the gate can only change while the clock is low.

Fourteen ungated clocks enter the block and fourteen gated clocks leave it. Two of them, index 8 and index 12, pass straight through and cannot be frozen. The feedback path and one reference output therefore keep running even if a frame is loaded wrongly. The receiver is a two-state machine. In `RX_IDLE` it waits for a low sample. The transition `RX_IDLE -> RX_SHIFT` is taken on a low `sdata` sample. `RX_IDLE -> RX_IDLE` is taken while `sdata` stays high. `RX_SHIFT -> RX_SHIFT` is taken while data bits are still outstanding. `RX_SHIFT -> RX_IDLE` is taken on the last data bit, and the register is written on that same edge.

Top module: `sfz_top`

## Requirements
- R1: `sdata` is sampled on rising `sclk` edges. A low sample taken in the idle state is a start bit, and the next 12 rising edges sample the 12 data bits.
- R2: All 12 enables are written together on the rising `sclk` edge that samples the 12th data bit. A start bit on the very next rising edge begins a new frame.
- R3: Data bit n (n = 1..12, in order of arrival) controls the output with index 0, 1, 2, 3, 4, 5, 6, 7, 9, 10, 11, 13 respectively.
- R4: An enable bit of 1 lets its output follow its input clock. An enable bit of 0 holds that output at logic 0.
- R5: Outputs 8 and 12 always equal their input clocks, whatever frames are loaded.
- R6: A gated output never produces a partial pulse. It rises only together with a rise of its input clock and falls only together with a fall of its input clock.
- R7: After the enable register changes, each affected output takes the new state once its own clock has had two rising edges and the low phase that follows them.
- R8: While `rst_n` is low, and after it is released, all enables are 1, so every output runs and the receiver waits in the idle state.
- R9: With `sdata` held high in the idle state, the enable register and every output's run/freeze state stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Free-running serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata | input | 1 | Serial frame data; idles high |
| clk_in | input | 14 | Ungated output clocks |
| clk_out | output | 14 | Gated output clocks |

## Verification
Two functions can land on neighbouring edges or on the same instant. The first is the commit of one frame followed by the start bit of the next. The bench sends frames back to back with no idle bit between them and checks that the second pattern is the one that settles on the outputs. The second is an enable change that arrives while an output clock is high. The fourteen input clocks all have different periods, so every commit lands on many different phases. A monitor sampling between clock edges counts any output transition that its input did not make at the same moment.

// File: rtl/sfz_pkg.sv
package sfz_pkg;

    localparam int NUM_OUT = 14;
    localparam int NUM_CTL = 12;
    localparam logic [31:0] EXEMPT_DEFAULT = 32'h0000_1100;

    typedef enum logic [0:0] {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_e;

    // Position in the frame of the enable for output out_idx:
    // the number of non-exempt outputs below it.
    function automatic int ctl_index(input logic [31:0] exempt, input int out_idx);
        int n;
        n = 0;
        for (int j = 0; j < out_idx; j++) begin
            if (!exempt[j]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/sfz_rx.sv
module sfz_rx
    import sfz_pkg::*;
#(
    parameter int NBITS = 12
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             sdata,
    output logic [NBITS-1:0] en_q
);

    localparam int CW = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

    rx_state_e        state_q, state_d;
    logic [CW-1:0]    cnt_q;
    logic [NBITS-1:0] sh_q;
    logic [NBITS:0]   sh_cat;
    logic [NBITS-1:0] sh_next;
    logic             last_bit;

    assign sh_cat   = {sdata, sh_q} >> 1;
    assign sh_next  = sh_cat[NBITS-1:0];
    assign last_bit = (cnt_q == LAST);

    // state register
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (!sdata)  state_d = RX_SHIFT;
            RX_SHIFT: if (last_bit) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    // datapath and output register
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '1;
            en_q  <= '1;
        end else begin
            unique case (state_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                end
                RX_SHIFT: begin
                    sh_q <= sh_next;
                    if (last_bit) begin
                        en_q  <= sh_next;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assert_count_range_R1: assert property (@(posedge sclk) disable iff (!rst_n)
        cnt_q <= LAST) else $error("bit counter out of range");

    assert_start_detect_R1: assert property (@(posedge sclk) disable iff (!rst_n)
        (state_q == RX_IDLE && !sdata) |=> (state_q == RX_SHIFT))
        else $error("start bit missed");

    assert_commit_at_end_R2: assert property (@(posedge sclk) disable iff (!rst_n)
        !$stable(en_q) |-> $past(state_q == RX_SHIFT && cnt_q == LAST))
        else $error("enables changed outside frame end");

    assert_idle_hold_R9: assert property (@(posedge sclk) disable iff (!rst_n)
        (state_q == RX_IDLE && sdata) |=> ($stable(en_q) && state_q == RX_IDLE))
        else $error("idle line disturbed enables");

endmodule

// File: rtl/sfz_gate.sv
module sfz_gate (
    input  logic clk_in,
    input  logic rst_n,
    input  logic en_async,
    output logic clk_out
);

    logic s1_q, s2_q, gate_q;

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= en_async;
            s2_q <= s1_q;
        end
    end

    // gate moves only on the falling edge, i.e. while the clock is low
    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b1;
        else        gate_q <= s2_q;
    end

    assign clk_out = clk_in & gate_q;

    always @(gate_q) begin
        if (rst_n) begin
            assert_gate_moves_low_R6: assert (clk_in == 1'b0)
                else $error("gate changed while clock high");
        end
    end

    assert_sync_chain_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
        s2_q == $past(s1_q)) else $error("synchroniser stage skipped");

endmodule

// File: rtl/sfz_top.sv
module sfz_top
    import sfz_pkg::*;
#(
    parameter int          N_OUT  = NUM_OUT,
    parameter int          N_CTL  = NUM_CTL,
    parameter logic [31:0] EXEMPT = EXEMPT_DEFAULT
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             sdata,
    input  logic [N_OUT-1:0] clk_in,
    output logic [N_OUT-1:0] clk_out
);

    logic [N_CTL-1:0] en_q;

    sfz_rx #(.NBITS(N_CTL)) rx_i (
        .sclk  (sclk),
        .rst_n (rst_n),
        .sdata (sdata),
        .en_q  (en_q)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        if (EXEMPT[i]) begin : g_pass
            assign clk_out[i] = clk_in[i];
        end else begin : g_gate
            localparam int CI = ctl_index(EXEMPT, i);
            sfz_gate gate_i (
                .clk_in   (clk_in[i]),
                .rst_n    (rst_n),
                .en_async (en_q[CI]),
                .clk_out  (clk_out[i])
            );
        end
    end

endmodule

// File: tb/sfz_top_tb_top.sv
`timescale 1ns/1ps
module sfz_top_tb_top;

    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdata = 1'b1;
    logic [13:0] clk_in;
    logic [13:0] clk_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 sclk = ~sclk;

    for (genvar g = 0; g < 14; g++) begin : g_clk
        logic c = 1'b0;
        always #(4 + g) c = ~c;
        assign clk_in[g] = c;
    end

    sfz_top dut_i (
        .sclk    (sclk),
        .rst_n   (rst_n),
        .sdata   (sdata),
        .clk_in  (clk_in),
        .clk_out (clk_out)
    );

    // monitor: sampled half a ns away from every edge
    logic [13:0] prev_in, prev_out;
    int in_edges [14];
    int out_edges[14];
    bit win = 0;
    int runt_cnt = 0;

    initial begin
        prev_in = '0;
        prev_out = '0;
        #0.5;
        forever begin
            for (int i = 0; i < 14; i++) begin
                if (rst_n) begin
                    if (clk_out[i] && !clk_in[i]) runt_cnt++;
                    if (clk_out[i] && !prev_out[i] && prev_in[i]) runt_cnt++;
                    if (!clk_out[i] && prev_out[i] && clk_in[i]) runt_cnt++;
                end
                if (win) begin
                    if (clk_in[i] && !prev_in[i]) in_edges[i]++;
                    if (clk_out[i] && !prev_out[i]) out_edges[i]++;
                end
            end
            prev_in = clk_in;
            prev_out = clk_out;
            #1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [13:0] map_bits(input logic [11:0] bits);
        int pos[12] = '{0, 1, 2, 3, 4, 5, 6, 7, 9, 10, 11, 13};
        logic [13:0] run;
        run = 14'h1100; // outputs 8 and 12 always run (R5)
        for (int k = 0; k < 12; k++) run[pos[k]] = bits[k];
        return run;
    endfunction

    // R7: settle window longer than 3 periods of the slowest clock
    task automatic expect_run(input logic [13:0] run, input string tag);
        #400;
        for (int i = 0; i < 14; i++) begin
            in_edges[i] = 0;
            out_edges[i] = 0;
        end
        win = 1;
        #1000;
        win = 0;
        for (int i = 0; i < 14; i++) begin
            int exp_e;
            exp_e = run[i] ? in_edges[i] : 0;
            chk(out_edges[i] == exp_e,
                $sformatf("%s out%0d edges%s", tag, i,
                          (i == 8 || i == 12) ? " R5" : " R3 R4 R7"),
                out_edges[i], exp_e);
            if (!run[i])
                chk(clk_out[i] == 1'b0, $sformatf("%s R4 out%0d frozen level", tag, i),
                    int'(clk_out[i]), 0);
        end
    endtask

    // R1 R2: start bit, 12 data bits, optionally no idle afterwards
    task automatic send_frame(input logic [11:0] bits, input bit idle_after);
        @(negedge sclk) sdata = 1'b0;
        for (int k = 0; k < 12; k++) @(negedge sclk) sdata = bits[k];
        if (idle_after) @(negedge sclk) sdata = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] pat;
        #103;
        // R8: reset state, all running
        chk(clk_out === clk_in, "R8 outputs follow during reset", int'(clk_out), int'(clk_in));
        rst_n = 1'b1;
        expect_run(14'h3fff, "R8 after reset");

        // R3 R4: all frozen, all running
        send_frame(12'h000, 1);
        expect_run(map_bits(12'h000), "R4 all zero");
        send_frame(12'hfff, 1);
        expect_run(map_bits(12'hfff), "R4 all one");

        // R3: walking zero and walking one
        for (int k = 0; k < 12; k++) begin
            pat = ~(12'h001 << k);
            send_frame(pat, 1);
            expect_run(map_bits(pat), $sformatf("R3 walk0 bit%0d", k));
        end
        for (int k = 0; k < 12; k++) begin
            pat = 12'h001 << k;
            send_frame(pat, 1);
            expect_run(map_bits(pat), $sformatf("R3 walk1 bit%0d", k));
        end

        // R2: frames back to back, second one wins
        send_frame(12'h5a5, 0);
        send_frame(12'h3c6, 1);
        expect_run(map_bits(12'h3c6), "R2 back to back");

        // R9: long idle high keeps the state
        repeat (300) @(negedge sclk) sdata = 1'b1;
        expect_run(map_bits(12'h3c6), "R9 idle hold");

        // R1: a frame whose first data bits are zero is taken as data
        send_frame(12'h0f0, 1);
        expect_run(map_bits(12'h0f0), "R1 leading zero data");

        // R8: reset while frozen reopens every output
        @(negedge sclk) rst_n = 1'b0;
        #200;
        @(negedge sclk) rst_n = 1'b1;
        expect_run(14'h3fff, "R8 reset while frozen");

        // R6: no partial pulse observed anywhere
        chk(runt_cnt == 0, "R6 partial pulses", runt_cnt, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule